// File: doc/BRIEF.md
# Ethernet Link Status Indicator Driver

This block turns PHY status levels and activity strobes into three active-low, open-drain indicator pins: one for link with activity blinking, one for the line rate, and one for duplex. Each pin is modelled as a pull-low enable. A 1 pulls the pad low and lights the LED. A 0 releases the pad, so an external or internal pull-up takes it high.

The link pin stays lit while the link is valid. When a transmit or receive strobe arrives, the pin goes dark for a fixed blink period. It then stays lit for at least one more blink period before it may blink again. Activity seen while a blink is in progress is remembered and served as soon as the guaranteed lit period ends. The speed and duplex pins are plain level decodes. A per-pin select bit hands the pad over to general-purpose use, and the indicator function then stops pulling it.

All timing comes from a millisecond tick that is derived from the clock frequency parameter. A simulation can therefore use a slow nominal clock to get short blink periods.

Top module: `eth_led_drive`

## Requirements
- R1: While `rst_n` is low at a clock edge, every bit of `led_pull` is 0 after that edge, whatever the inputs are.
- R2: With a valid link and no activity, `led_pull[1]` is 1. Every pin output is registered: it reflects the inputs sampled at the previous clock edge.
- R3: An activity strobe (`phy_tx_act` or `phy_rx_act` high at an edge) seen while the link pin is steadily lit makes `led_pull[1]` 0. This starts one cycle after that edge and lasts exactly BLINK_MS × (CLK_HZ / TICK_HZ) cycles.
- R4: After the dark period, `led_pull[1]` is 1 for exactly one more blink period. The pin then goes dark again at once if activity was seen at any edge during the dark or lit-hold period, including the edge at which the hold ends. Otherwise it stays lit.
- R5: Several strobes during one dark-plus-hold window produce only one further blink.
- R6: When `phy_link_up` is low at an edge, `led_pull[1]` is 0 after that edge. Any remembered activity and the blink timers are discarded, so a returning link lights the pin steadily with no blink.
- R7: `led_pull[2]` (speed) is 0 when `phy_isolate` is high. Otherwise it is 1 when `phy_aneg_busy` or `phy_speed_100` is high. It is 0 otherwise.
- R8: `led_pull[0]` (duplex) is 1 exactly when both `phy_link_up` and `phy_full_duplex` are high.
- R9: When `gpio_sel[i]` is 1 at an edge, `led_pull[i]` is 0 after that edge. Bit order is 0 duplex, 1 link/activity, 2 speed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| phy_link_up | input | 1 | PHY reports a valid link |
| phy_speed_100 | input | 1 | Link runs at 100 Mb/s (0 means 10 Mb/s) |
| phy_full_duplex | input | 1 | Link runs in full duplex |
| phy_aneg_busy | input | 1 | Auto-negotiation in progress |
| phy_isolate | input | 1 | PHY is electrically isolated from the line |
| phy_tx_act | input | 1 | Transmit activity strobe |
| phy_rx_act | input | 1 | Receive activity strobe |
| gpio_sel | input | 3 | Per-pin hand-over to general-purpose use |
| led_pull | output | 3 | Per-pin pull-low enable (1 means the LED is lit) |

## Verification
Two cases share a cycle. In the first, an activity strobe is applied exactly at the edge where the lit-hold period expires. The bench judges it by requiring the next dark period to start one cycle later, with no extra lit cycle. In the second, the link is dropped exactly at the edge where the dark period ends and while activity is pending. The bench judges it by requiring the pin to stay dark until the link returns, and then to stay steadily lit instead of serving the discarded blink. Both cases are checked cycle by cycle against a dark/lit window computed from the blink length.

// File: rtl/eth_led_pkg.sv
`timescale 1ns/1ps
// Shared definitions for the Ethernet status indicator driver.
// Assumes the three pins are indexed as listed below. The pin multiplexer
// outside the block relies on this order.
package eth_led_pkg;
    localparam int LED_CNT = 3;
    localparam int IDX_DUP = 0;
    localparam int IDX_LNK = 1;
    localparam int IDX_SPD = 2;

    // Phases of the link/activity indicator
    typedef enum logic [1:0] {
        BL_SOLID = 2'd0,   // lit steadily, no blink running
        BL_DARK  = 2'd1,   // blink off period
        BL_HOLD  = 2'd2    // guaranteed lit period after a blink
    } blink_st_t;
endpackage

// File: rtl/led_ms_tick.sv
`timescale 1ns/1ps
// Millisecond tick generator.
// Emits a one-cycle tick every CLK_HZ/TICK_HZ cycles. A restart request
// realigns the count, so a phase that starts at a restart lasts an exact
// number of clock cycles. Assumes CLK_HZ >= TICK_HZ; otherwise the
// divider degenerates to a tick on every cycle.
module led_ms_tick #(
    parameter int CLK_HZ  = 125_000_000,
    parameter int TICK_HZ = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic tick
);
    localparam int DIV = (CLK_HZ / TICK_HZ < 1) ? 1 : CLK_HZ / TICK_HZ;
    localparam int DW  = $clog2(DIV + 1);

    logic [DW-1:0] div_cnt;

    assign tick = (div_cnt == DW'(DIV - 1));

    // Divider counter: cleared on restart, wraps after the tick cycle
    always_ff @(posedge clk) begin
        if (!rst_n || restart || tick) begin
            div_cnt <= '0;
        end else begin
            div_cnt <= div_cnt + 1'b1;
        end
    end

    // Counter never passes the tick value (timing base of R3)
    p_div_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        div_cnt < DW'(DIV));
endmodule

// File: rtl/led_act_blink.sv
`timescale 1ns/1ps
// Link/activity indicator sequencer.
// Holds the LED lit while the link is up. An activity strobe starts a dark
// period of BLINK_MS ticks, followed by a lit hold of BLINK_MS ticks.
// Activity seen during either period is remembered and starts the next
// blink when the hold ends. Loss of link clears everything. Assumes
// `tick` comes from a divider that this module restarts on phase entry.
module led_act_blink
    import eth_led_pkg::*;
#(
    parameter int BLINK_MS = 80
) (
    input  logic clk,
    input  logic rst_n,
    input  logic link_up,
    input  logic act,
    input  logic tick,
    output logic restart,
    output logic led_on
);
    localparam int CW = $clog2(BLINK_MS + 1);

    blink_st_t     st, st_n;
    logic [CW-1:0] ms_cnt, ms_cnt_n;
    logic          pend, pend_n;
    logic          phase_end;

    assign phase_end = tick && (ms_cnt == CW'(BLINK_MS - 1));
    assign led_on    = link_up && (st != BL_DARK);

    // Next-state logic of the blink sequencer
    always_comb begin
        st_n     = st;
        ms_cnt_n = ms_cnt;
        pend_n   = pend;
        restart  = 1'b0;
        if (!link_up) begin
            st_n     = BL_SOLID;
            ms_cnt_n = '0;
            pend_n   = 1'b0;
            restart  = 1'b1;
        end else begin
            case (st)
                BL_SOLID: begin
                    if (act) begin
                        st_n     = BL_DARK;
                        ms_cnt_n = '0;
                        restart  = 1'b1;
                    end
                end
                BL_DARK: begin
                    if (act) pend_n = 1'b1;
                    if (phase_end) begin
                        st_n     = BL_HOLD;
                        ms_cnt_n = '0;
                        restart  = 1'b1;
                    end else if (tick) begin
                        ms_cnt_n = ms_cnt + 1'b1;
                    end
                end
                BL_HOLD: begin
                    if (act) pend_n = 1'b1;
                    if (phase_end) begin
                        ms_cnt_n = '0;
                        if (pend || act) begin
                            st_n    = BL_DARK;
                            pend_n  = 1'b0;
                            restart = 1'b1;
                        end else begin
                            st_n = BL_SOLID;
                        end
                    end else if (tick) begin
                        ms_cnt_n = ms_cnt + 1'b1;
                    end
                end
                default: begin
                    st_n     = BL_SOLID;
                    ms_cnt_n = '0;
                    pend_n   = 1'b0;
                end
            endcase
        end
    end

    // State, phase timer and pending-activity registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st     <= BL_SOLID;
            ms_cnt <= '0;
            pend   <= 1'b0;
        end else begin
            st     <= st_n;
            ms_cnt <= ms_cnt_n;
            pend   <= pend_n;
        end
    end

    // Phase timer stays within one blink period
    p_cnt_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ms_cnt < CW'(BLINK_MS));
    // A blink can only be running if the link was up one cycle earlier
    p_dark_needs_link_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (st != BL_SOLID) |-> $past(link_up));
    // Remembered activity never survives into the steady lit phase
    p_no_pend_solid_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (st == BL_SOLID) |-> !pend);
    // Link loss discards the sequence and any pending blink
    p_drop_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !link_up |=> (st == BL_SOLID) && !pend && (ms_cnt == '0));
endmodule

// File: rtl/led_od_pad.sv
`timescale 1ns/1ps
// Open-drain pad driver for one indicator pin.
// Registers the pull-low enable. It releases the pad whenever the pin is
// handed to general-purpose use. Assumes an external pull-up provides the
// high level.
module led_od_pad (
    input  logic clk,
    input  logic rst_n,
    input  logic func_on,
    input  logic gpio_sel,
    output logic pull_low
);
    // Output register: pull low only when lit and still owned by the LED
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pull_low <= 1'b0;
        end else begin
            pull_low <= func_on && !gpio_sel;
        end
    end

    // A pin given to general-purpose use is released one cycle later
    p_gpio_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
        gpio_sel |=> !pull_low);
endmodule

// File: rtl/eth_led_drive.sv
`timescale 1ns/1ps
// Ethernet status indicator driver (top).
// Decodes PHY status into three active-low open-drain LED pins: duplex,
// link/activity with timed blinking, and speed. Assumes status inputs are
// synchronous to clk and activity inputs are single-cycle or level strobes.
module eth_led_drive
    import eth_led_pkg::*;
#(
    parameter int CLK_HZ   = 125_000_000,
    parameter int TICK_HZ  = 1000,
    parameter int BLINK_MS = 80
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               phy_link_up,
    input  logic               phy_speed_100,
    input  logic               phy_full_duplex,
    input  logic               phy_aneg_busy,
    input  logic               phy_isolate,
    input  logic               phy_tx_act,
    input  logic               phy_rx_act,
    input  logic [LED_CNT-1:0] gpio_sel,
    output logic [LED_CNT-1:0] led_pull
);
    logic               ms_tick;
    logic               tick_restart;
    logic               lnk_on;
    logic [LED_CNT-1:0] func_on;

    led_ms_tick #(
        .CLK_HZ (CLK_HZ),
        .TICK_HZ(TICK_HZ)
    ) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .restart(tick_restart),
        .tick   (ms_tick)
    );

    led_act_blink #(
        .BLINK_MS(BLINK_MS)
    ) u_blink (
        .clk    (clk),
        .rst_n  (rst_n),
        .link_up(phy_link_up),
        .act    (phy_tx_act || phy_rx_act),
        .tick   (ms_tick),
        .restart(tick_restart),
        .led_on (lnk_on)
    );

    // Level decodes of speed and duplex, plus the sequenced link pin
    always_comb begin
        func_on          = '0;
        func_on[IDX_DUP] = phy_link_up && phy_full_duplex;
        func_on[IDX_LNK] = lnk_on;
        func_on[IDX_SPD] = !phy_isolate && (phy_aneg_busy || phy_speed_100);
    end

    for (genvar g = 0; g < LED_CNT; g++) begin : g_pad
        led_od_pad u_pad (
            .clk     (clk),
            .rst_n   (rst_n),
            .func_on (func_on[g]),
            .gpio_sel(gpio_sel[g]),
            .pull_low(led_pull[g])
        );
    end

    // Isolation darkens the speed pin on the next cycle
    p_iso_dark_r7: assert property (@(posedge clk) disable iff (!rst_n)
        phy_isolate |=> !led_pull[IDX_SPD]);
    // Half duplex or no link darkens the duplex pin on the next cycle
    p_half_dark_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!phy_full_duplex || !phy_link_up) |=> !led_pull[IDX_DUP]);
    // Loss of link darkens the link pin on the next cycle
    p_link_dark_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !phy_link_up |=> !led_pull[IDX_LNK]);
endmodule

// File: tb/eth_led_drive_test.sv
`timescale 1ns/1ps
module eth_led_drive_test;
    localparam int CLK_HZ   = 4000;
    localparam int TICK_HZ  = 1000;
    localparam int BLINK_MS = 3;
    localparam int PH       = BLINK_MS * (CLK_HZ / TICK_HZ);   // 12 cycles

    logic       clk = 1'b0;
    logic       rst_n;
    logic       link, spd, fdx, aneg, iso, tx, rx;
    logic [2:0] gsel;
    logic [2:0] pull;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #4 clk = ~clk;

    eth_led_drive #(
        .CLK_HZ  (CLK_HZ),
        .TICK_HZ (TICK_HZ),
        .BLINK_MS(BLINK_MS)
    ) uut (
        .clk            (clk),
        .rst_n          (rst_n),
        .phy_link_up    (link),
        .phy_speed_100  (spd),
        .phy_full_duplex(fdx),
        .phy_aneg_busy  (aneg),
        .phy_isolate    (iso),
        .phy_tx_act     (tx),
        .phy_rx_act     (rx),
        .gpio_sel       (gsel),
        .led_pull       (pull)
    );

    // Vector: {link, spd, fdx, aneg, iso, gsel[2:0], exp[2:0]}
    localparam int NV = 9;
    localparam logic [10:0] VEC [NV] = '{
        {5'b11100, 3'b000, 3'b111},   // R7 R8 100M full
        {5'b10100, 3'b000, 3'b011},   // R7 10M full
        {5'b10010, 3'b000, 3'b110},   // R7 aneg lights speed, R8 half
        {5'b11101, 3'b000, 3'b011},   // R7 isolation wins
        {5'b01100, 3'b000, 3'b100},   // R8 no link, R6 link dark
        {5'b00011, 3'b000, 3'b000},   // R7 isolate during aneg
        {5'b11100, 3'b101, 3'b010},   // R9 speed and duplex released
        {5'b11100, 3'b010, 3'b101},   // R9 link pin released
        {5'b10000, 3'b000, 3'b010}    // R2 link only
    };

    task automatic chk(input string req, input logic [2:0] got,
                       input logic [2:0] exp, input int tag);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s step %0d: actual %b expected %b", req, tag, got, exp);
        end
    endtask

    // Blink window checker: one activity pulse, then a cycle loop.
    // mode 0: extra strobe exactly at hold end (R4 same cycle)
    // mode 1: strobes during dark and hold (R4, R5)
    // mode 2: pending strobe, then link drop at dark end (R6)
    task automatic blink_run(input int mode, input int len);
        logic e;
        @(negedge clk); tx = 1'b1;
        @(negedge clk); tx = 1'b0;
        chk("R3 latency", {2'b00, pull[1]}, 3'b001, 0);
        for (int m = 1; m <= len; m++) begin
            @(negedge clk);
            case (mode)
                0: e = !((m >= 1 && m <= PH) || (m >= 2*PH+1 && m <= 3*PH));
                1: e = !((m >= 1 && m <= PH) || (m >= 2*PH+1 && m <= 3*PH));
                default: e = (m > PH + 2);
            endcase
            chk(mode == 0 ? "R3 R4" : (mode == 1 ? "R4 R5" : "R6"),
                {2'b00, pull[1]}, {2'b00, e}, m);
            case (mode)
                0: tx = (m == 2*PH - 1);
                1: rx = (m == 5) || (m == PH + 3);
                default: begin
                    rx = (m == 3);
                    if (m == PH - 1) link = 1'b0;
                    if (m == PH + 2) link = 1'b1;
                end
            endcase
        end
        tx = 1'b0; rx = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        {link, spd, fdx, aneg, iso, tx, rx} = 7'b1110011;
        gsel = 3'b000;
        repeat (3) @(negedge clk);
        chk("R1 reset", pull, 3'b000, 0);
        tx = 1'b0; rx = 1'b0;
        {link, spd, fdx, aneg, iso} = 5'b00000;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 after reset", pull, 3'b000, 1);

        for (int i = 0; i < NV; i++) begin
            {link, spd, fdx, aneg, iso} = VEC[i][10:6];
            gsel = VEC[i][5:3];
            @(negedge clk);
            chk("R2 R7 R8 R9 vector", pull, VEC[i][2:0], i);
        end

        // Steady link, no activity (R2)
        {link, spd, fdx, aneg, iso} = 5'b11100;
        gsel = 3'b000;
        repeat (20) @(negedge clk);
        chk("R2 steady", pull, 3'b111, 0);

        blink_run(0, 5*PH);
        repeat (5) @(negedge clk);
        blink_run(1, 4*PH + 2);
        repeat (5) @(negedge clk);
        blink_run(2, 3*PH);

        // GPIO hand-over during a blink keeps the pin released (R9)
        @(negedge clk); tx = 1'b1; gsel = 3'b010;
        @(negedge clk); tx = 1'b0;
        repeat (2*PH + 4) @(negedge clk);
        chk("R9 during blink", pull, 3'b101, 0);
        gsel = 3'b000;
        @(negedge clk);
        chk("R9 return", pull, 3'b111, 1);

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end
endmodule